// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block sits between a small 8-bit processor core and an external memory bus that shares one byte lane between the low address and the data. The core presents a request with a 16-bit address, a direction flag and, for writes, a data byte. The block then runs a machine cycle on the bus. In the first clock the address strobe pulses and the shared lane carries the low address byte. In the next clock or clocks the data strobe is asserted, and the shared lane either carries write data or is released so that memory can drive read data. A final recovery clock closes the cycle. A separate upper lane carries the high address bits. Under a mode bit it drives either the whole high byte or only its low nibble, and in the second case it leaves the high nibble to general-purpose use.

A mode register holds two bits: the upper-lane width and an extended-timing bit. The extended-timing bit stretches the data-strobe phase by wait clocks for slow memory. After reset both bits are set, so that a core booting from external memory works with slow parts and the full 16-bit address. The core clears extended timing later.

The bus can be handed to another master. A release request from the core is passed to the bus-request output. Once the acknowledge input is seen at a cycle boundary, every bus output enable is dropped together. New core requests are stalled until the acknowledge is withdrawn.

Top module: `xmb_bus_if`

## Requirements
- R1: After reset, as_n_out, ds_n_out and rw_out are 1, ctl_oe is 1, ad_oe is 0, bus_req is 0, rd_valid is 0 and req_ready is 1.
- R2: Each accepted transfer drives as_n_out low for exactly one clock, the first clock of the transfer. During that clock ad_oe is 1 and ad_out carries address bits 7..0.
- R3: ds_n_out goes low once per transfer, starting in the clock right after the address-strobe clock. It stays low for 1 clock when extended timing is 0 and for 1+EXT_WAIT clocks (2 by default) when it is 1. It then returns high for one recovery clock.
- R4: On a read, ad_oe is 0 while ds_n_out is low. The value on ad_in in the last clock before ds_n_out rises is returned on rd_data, and rd_valid is a one-clock pulse during the recovery clock.
- R5: On a write, rw_out is 0 from the address-strobe clock through the recovery clock. From the first data-strobe clock through recovery, ad_oe is 1 and ad_out carries the write data. On reads and in idle, rw_out is 1.
- R6: Upper lane, mode bit wide=1: ahi_out equals address bits 15..8 and ahi_oe is 2'b11. Upper lane, wide=0: ahi_out[3:0] equals address bits 11..8, ahi_out[7:4] is 0, and ahi_oe is 2'b01 (bit i enables nibble i).
- R7: A clock with cfg_we=1 loads wide from cfg_wide and extended timing from cfg_ext. After reset, wide is 1 and extended timing is 1.
- R8: req_ready is 1 only in idle or in the recovery clock while rel_req is 0. A request accepted in the recovery clock starts its address-strobe clock in the next clock.
- R9: bus_req equals rel_req delayed by one clock.
- R10: The bus is released only at a cycle boundary (idle or recovery) with rel_req and bus_ack both 1. A transfer in flight always finishes with its strobes driven. When released, ctl_oe, ad_oe and both ahi_oe bits are 0.
- R11: While released, req_ready is 0 and no transfer starts. In the clock after bus_ack is sampled 0, drive is restored and pending requests are accepted.
- R12: bus_ack while rel_req is 0 has no effect: outputs stay driven and transfers run normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core transfer request |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| cfg_we | input | 1 | Mode register write enable |
| cfg_wide | input | 1 | New upper-lane width (1 = full byte) |
| cfg_ext | input | 1 | New extended-timing bit |
| rel_req | input | 1 | Core asks to surrender the bus |
| bus_req | output | 1 | Bus request to the other master |
| bus_ack | input | 1 | Bus acknowledge from the other master |
| ad_out | output | 8 | Shared address/data lane, output value |
| ad_oe | output | 1 | Shared lane output enable |
| ad_in | input | 8 | Shared lane, input value |
| ahi_out | output | 8 | Upper address lane value |
| ahi_oe | output | 2 | Upper lane output enable per nibble |
| as_n_out | output | 1 | Address strobe, active low |
| ds_n_out | output | 1 | Data strobe, active low |
| rw_out | output | 1 | Read/write, low on writes |
| ctl_oe | output | 1 | Output enable for the three strobe lines |

## Verification
The bench sweeps all four mode combinations across reads and writes and follows each transfer clock by clock. A sequencer that stretched or doubled a strobe, or captured read data one clock early, would show a wrong strobe width or stale data. In extended mode the bench puts a decoy value on the lane in the first data-strobe clock. Back-to-back transfers start from the recovery clock, which catches a block that drops the request or inserts an idle clock. The release tests assert the acknowledge mid-transfer, without a request, and while a core request is pending. A block that tri-states mid-cycle, reacts to a stray acknowledge, or starts a transfer while surrendered would misdrive the enables or strobes.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

    localparam int ADDR_W_DEF   = 16;
    localparam int DATA_W_DEF   = 8;
    localparam int EXT_WAIT_DEF = 1;

    // sequencer phases; one bus machine cycle is ADDR, DATA, [WAIT...], RECOV
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DATA  = 3'd2,
        PH_WAIT  = 3'd3,
        PH_RECOV = 3'd4,
        PH_YIELD = 3'd5
    } phase_t;

    typedef struct packed {
        logic wide;   // 1: full upper byte, 0: low nibble only
        logic ext;    // 1: stretched data strobe
    } mode_t;

    localparam mode_t MODE_AT_RESET = '{wide: 1'b1, ext: 1'b1};

    typedef struct packed {
        logic as_n;
        logic ds_n;
        logic rw;
        logic ad_oe;
        logic ad_data;   // 1: data on shared lane, 0: address
        logic drive;     // 0: bus surrendered
    } strobe_t;

    function automatic logic is_boundary(phase_t p);
        return (p == PH_IDLE) || (p == PH_RECOV);
    endfunction

    function automatic logic in_strobe(phase_t p);
        return (p == PH_DATA) || (p == PH_WAIT);
    endfunction

    function automatic strobe_t decode_strobes(phase_t p, logic wr);
        strobe_t s;
        s.as_n    = (p != PH_ADDR);
        s.ds_n    = !in_strobe(p);
        s.rw      = !(wr && (p == PH_ADDR || in_strobe(p) || p == PH_RECOV));
        s.ad_oe   = (p == PH_ADDR) || (wr && (in_strobe(p) || p == PH_RECOV));
        s.ad_data = (p != PH_ADDR);
        s.drive   = (p != PH_YIELD);
        return s;
    endfunction

endpackage

// File: rtl/xmb_mode_reg.sv
module xmb_mode_reg
    import xmb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_we,
    input  logic  cfg_wide,
    input  logic  cfg_ext,
    output mode_t mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_AT_RESET;
        end else if (cfg_we) begin
            mode.wide <= cfg_wide;
            mode.ext  <= cfg_ext;
        end
    end

endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
    import xmb_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int EXT_WAIT = EXT_WAIT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  mode_t             mode,
    input  logic              rel_req,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] ad_in,
    output strobe_t           strb,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_req
);

    localparam int WC_W = (EXT_WAIT < 1) ? 1 : $clog2(EXT_WAIT + 1);
    localparam logic [WC_W-1:0] WC_LOAD = WC_W'(EXT_WAIT);

    phase_t          ph;
    logic            x_wr;
    logic            x_ext;
    logic [WC_W-1:0] wcnt;
    logic            accept;
    logic            yield_now;

    assign req_ready = is_boundary(ph) && !rel_req;
    assign accept    = req_ready && req_valid;
    assign yield_now = is_boundary(ph) && rel_req && bus_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            x_wr      <= 1'b0;
            x_ext     <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            wcnt      <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            bus_req   <= 1'b0;
        end else begin
            bus_req  <= rel_req;
            rd_valid <= 1'b0;
            unique case (ph)
                PH_IDLE, PH_RECOV: begin
                    if (yield_now) begin
                        ph <= PH_YIELD;
                    end else if (accept) begin
                        ph        <= PH_ADDR;
                        cur_addr  <= req_addr;
                        cur_wdata <= req_wdata;
                        x_wr      <= req_write;
                        x_ext     <= mode.ext;
                    end else begin
                        ph <= PH_IDLE;
                    end
                end
                PH_ADDR: begin
                    ph   <= PH_DATA;
                    wcnt <= WC_LOAD;
                end
                PH_DATA: begin
                    if (x_ext && (EXT_WAIT > 0)) begin
                        ph <= PH_WAIT;
                    end else begin
                        ph       <= PH_RECOV;
                        rd_valid <= !x_wr;
                        if (!x_wr) rd_data <= ad_in;
                    end
                end
                PH_WAIT: begin
                    if (wcnt <= WC_W'(1)) begin
                        ph       <= PH_RECOV;
                        rd_valid <= !x_wr;
                        if (!x_wr) rd_data <= ad_in;
                    end else begin
                        wcnt <= wcnt - WC_W'(1);
                    end
                end
                PH_YIELD: begin
                    if (!bus_ack) ph <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        strb = decode_strobes(ph, x_wr);
    end

    // R3: data strobe phase is only entered straight from the address phase
    p_ds_after_as_r3: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DATA) |-> ($past(ph) == PH_ADDR));

    // R4: read-data valid is a single-clock pulse
    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R9: bus request tracks the core's release request
    p_busreq_follow_r9: assert property (@(posedge clk) disable iff (rst)
        rel_req |=> bus_req);

    // R10: surrender begins only from a cycle boundary
    p_yield_boundary_r10: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_YIELD && $past(ph) != PH_YIELD)
            |-> ($past(ph) == PH_IDLE || $past(ph) == PH_RECOV));

    // R11: no transfer starts straight out of surrender
    p_yield_exit_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(ph) == PH_YIELD) |-> (ph == PH_YIELD || ph == PH_IDLE));

endmodule

// File: rtl/xmb_lanes.sv
module xmb_lanes
    import xmb_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int DATA_W     = DATA_W_DEF,
    parameter int NARROW_NIB = 1
) (
    input  strobe_t                      strb,
    input  logic [ADDR_W-1:0]            cur_addr,
    input  logic [DATA_W-1:0]            cur_wdata,
    input  logic                         wide,
    output logic [DATA_W-1:0]            ad_out,
    output logic                         ad_oe,
    output logic [ADDR_W-DATA_W-1:0]     ahi_out,
    output logic [(ADDR_W-DATA_W)/4-1:0] ahi_oe,
    output logic                         as_n_out,
    output logic                         ds_n_out,
    output logic                         rw_out,
    output logic                         ctl_oe
);

    localparam int HI_W = ADDR_W - DATA_W;
    localparam int NIB  = HI_W / 4;

    assign ad_out   = strb.ad_data ? cur_wdata : cur_addr[DATA_W-1:0];
    assign ad_oe    = strb.ad_oe && strb.drive;
    assign as_n_out = strb.as_n;
    assign ds_n_out = strb.ds_n;
    assign rw_out   = strb.rw;
    assign ctl_oe   = strb.drive;

    for (genvar i = 0; i < NIB; i++) begin : g_nib
        logic used;
        assign used              = wide || (i < NARROW_NIB);
        assign ahi_oe[i]         = used && strb.drive;
        assign ahi_out[4*i +: 4] = used ? cur_addr[DATA_W + 4*i +: 4] : 4'h0;
    end

endmodule

// File: rtl/xmb_bus_if.sv
module xmb_bus_if
    import xmb_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int DATA_W     = DATA_W_DEF,
    parameter int EXT_WAIT   = EXT_WAIT_DEF,
    parameter int NARROW_NIB = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic                         req_write,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         req_ready,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         cfg_we,
    input  logic                         cfg_wide,
    input  logic                         cfg_ext,
    input  logic                         rel_req,
    output logic                         bus_req,
    input  logic                         bus_ack,
    output logic [DATA_W-1:0]            ad_out,
    output logic                         ad_oe,
    input  logic [DATA_W-1:0]            ad_in,
    output logic [ADDR_W-DATA_W-1:0]     ahi_out,
    output logic [(ADDR_W-DATA_W)/4-1:0] ahi_oe,
    output logic                         as_n_out,
    output logic                         ds_n_out,
    output logic                         rw_out,
    output logic                         ctl_oe
);

    mode_t             mode;
    strobe_t           strb;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    xmb_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_wide (cfg_wide),
        .cfg_ext  (cfg_ext),
        .mode     (mode)
    );

    xmb_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .EXT_WAIT (EXT_WAIT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .mode      (mode),
        .rel_req   (rel_req),
        .bus_ack   (bus_ack),
        .ad_in     (ad_in),
        .strb      (strb),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .bus_req   (bus_req)
    );

    xmb_lanes #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .NARROW_NIB (NARROW_NIB)
    ) u_lanes (
        .strb      (strb),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .wide      (mode.wide),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ahi_out   (ahi_out),
        .ahi_oe    (ahi_oe),
        .as_n_out  (as_n_out),
        .ds_n_out  (ds_n_out),
        .rw_out    (rw_out),
        .ctl_oe    (ctl_oe)
    );

    // R2: the address strobe is a one-clock pulse
    p_as_one_clk_r2: assert property (@(posedge clk) disable iff (rst)
        !as_n_out |=> as_n_out);

    // R3: the data strobe follows the address strobe in the very next clock
    p_ds_follows_as_r3: assert property (@(posedge clk) disable iff (rst)
        !as_n_out |=> !ds_n_out);

    // R5: read/write does not move while the data strobe is low
    p_rw_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!ds_n_out && !$past(ds_n_out)) |-> $stable(rw_out));

    // R6: the low upper nibble is driven whenever the bus is owned
    p_upper_low_nib_r6: assert property (@(posedge clk) disable iff (rst)
        ctl_oe |-> ahi_oe[0]);

    // R10: drive is dropped only after a cycle with both strobes idle
    p_release_boundary_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_oe) |-> ($past(as_n_out) && $past(ds_n_out)));

    // R11: no acceptance while surrendered
    p_no_ready_released_r11: assert property (@(posedge clk) disable iff (rst)
        !ctl_oe |-> !req_ready);

endmodule

// File: tb/tb_xmb_bus_if.sv
`timescale 1ns/1ps
module tb_xmb_bus_if;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        cfg_we = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_ext = 1'b0;
    logic        rel_req = 1'b0;
    logic        bus_req;
    logic        bus_ack = 1'b0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ahi_out;
    logic [1:0]  ahi_oe;
    logic        as_n_out;
    logic        ds_n_out;
    logic        rw_out;
    logic        ctl_oe;

    int nvec = 0;
    int nbad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xmb_bus_if dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cfg_we(cfg_we), .cfg_wide(cfg_wide), .cfg_ext(cfg_ext),
        .rel_req(rel_req), .bus_req(bus_req), .bus_ack(bus_ack),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .ahi_out(ahi_out), .ahi_oe(ahi_oe),
        .as_n_out(as_n_out), .ds_n_out(ds_n_out), .rw_out(rw_out),
        .ctl_oe(ctl_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] memval(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    task automatic set_mode(input logic w, input logic e);
        cfg_we = 1'b1; cfg_wide = w; cfg_ext = e;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Called right after a negedge with the block at a boundary.
    task automatic xfer(input logic [15:0] a, input logic wr, input logic [7:0] wd,
                        input logic wide, input logic ext);
        logic [7:0] mv;
        logic [7:0] hi_exp;
        logic [1:0] oe_exp;
        int nds;
        mv     = memval(a);
        hi_exp = wide ? a[15:8] : {4'h0, a[11:8]};
        oe_exp = wide ? 2'b11 : 2'b01;
        nds    = ext ? 2 : 1;
        chk("R8 ready at boundary", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
        @(negedge clk);                       // address clock
        req_valid = 1'b0;
        chk("R2 as low", as_n_out, 0);
        chk("R2 ds high in addr clock", ds_n_out, 1);
        chk("R2 lane drives address", {ad_oe, ad_out}, {1'b1, a[7:0]});
        chk("R5 rw in addr clock", rw_out, !wr);
        chk("R6 upper lane value", ahi_out, hi_exp);
        chk("R6 upper lane enables", ahi_oe, oe_exp);
        chk("R8 not ready mid transfer", req_ready, 0);
        for (int k = 0; k < nds; k++) begin
            @(negedge clk);                   // data strobe clocks
            chk("R3 ds low", ds_n_out, 0);
            chk("R2 as released", as_n_out, 1);
            chk("R5 rw in data clock", rw_out, !wr);
            if (wr) chk("R5 write data on lane", {ad_oe, ad_out}, {1'b1, wd});
            else    chk("R4 lane released on read", ad_oe, 0);
            ad_in = (k == nds - 1) ? mv : ~mv;
        end
        @(negedge clk);                       // recovery clock
        chk("R3 ds back high", ds_n_out, 1);
        chk("R2 no second as", as_n_out, 1);
        if (wr) begin
            chk("R5 rw held in recovery", rw_out, 0);
            chk("R5 data held in recovery", {ad_oe, ad_out}, {1'b1, wd});
            chk("R4 no rd_valid on write", rd_valid, 0);
        end else begin
            chk("R4 rd_valid", rd_valid, 1);
            chk("R4 rd_data", rd_data, mv);
            chk("R5 rw high on read", rw_out, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 as_n", as_n_out, 1);
        chk("R1 ds_n", ds_n_out, 1);
        chk("R1 rw", rw_out, 1);
        chk("R1 ctl_oe", ctl_oe, 1);
        chk("R1 ad_oe", ad_oe, 0);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 ready", req_ready, 1);
        // R7 reset mode: wide and extended
        chk("R7 reset wide", ahi_oe, 2'b11);
        xfer(16'hBEEF, 1'b0, 8'h00, 1'b1, 1'b1);

        // sweep all modes, reads and writes, back to back (R8)
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            set_mode(m[1], m[0]);
            for (int i = 0; i < 8; i++) begin
                logic [15:0] a;
                a = 16'(i * 16'h2E9B + m * 16'h1111 + 16'h0413);
                xfer(a, i[0] ^ m[0], 8'(i * 37 + m * 5 + 1), m[1], m[0]);
            end
            @(negedge clk);
            chk("R8 idle after last transfer", as_n_out, 1);
            chk("R4 no stray rd_valid", rd_valid, 0);
        end

        // R12: acknowledge without a release request
        set_mode(1'b1, 1'b0);
        bus_ack = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R12 still driven", ctl_oe, 1);
        chk("R12 still ready", req_ready, 1);
        xfer(16'h5A3C, 1'b1, 8'h77, 1'b1, 1'b0);
        xfer(16'h5A3D, 1'b0, 8'h00, 1'b1, 1'b0);
        bus_ack = 1'b0;
        @(negedge clk);

        // R9..R11: release from idle with a pending request
        rel_req = 1'b1;
        req_valid = 1'b1; req_addr = 16'h1234; req_write = 1'b0;
        @(negedge clk);
        chk("R9 bus_req follows", bus_req, 1);
        chk("R8 not ready with rel_req", req_ready, 0);
        chk("R10 not released before ack", ctl_oe, 1);
        chk("R8 no transfer started", as_n_out, 1);
        bus_ack = 1'b1;
        @(negedge clk);
        chk("R10 ctl_oe released", ctl_oe, 0);
        chk("R10 ad_oe released", ad_oe, 0);
        chk("R10 ahi_oe released", ahi_oe, 2'b00);
        chk("R11 not ready when released", req_ready, 0);
        rel_req = 1'b0;
        @(negedge clk);
        chk("R9 bus_req drops", bus_req, 0);
        chk("R11 held while ack high", ctl_oe, 0);
        chk("R11 no read while released", rd_valid, 0);
        bus_ack = 1'b0;
        @(negedge clk);
        chk("R11 drive restored", ctl_oe, 1);
        chk("R11 ready again", req_ready, 1);
        req_valid = 1'b0;
        xfer(16'h1234, 1'b0, 8'h00, 1'b1, 1'b0);

        // R10: acknowledge arrives mid-transfer; transfer must finish
        @(negedge clk);
        set_mode(1'b0, 1'b0);
        req_valid = 1'b1; req_addr = 16'hC9E1; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; rel_req = 1'b1; bus_ack = 1'b1;
        chk("R2 as low before release", as_n_out, 0);
        @(negedge clk);
        chk("R10 driven during ds", ctl_oe, 1);
        chk("R3 ds low during release request", ds_n_out, 0);
        ad_in = memval(16'hC9E1);
        @(negedge clk);
        chk("R10 driven in recovery", ctl_oe, 1);
        chk("R4 read completes", {rd_valid, rd_data}, {1'b1, memval(16'hC9E1)});
        @(negedge clk);
        chk("R10 released after boundary", ctl_oe, 0);
        rel_req = 1'b0; bus_ack = 1'b0;
        @(negedge clk);
        chk("R11 restored", ctl_oe, 1);
        chk("R6 narrow upper enables", ahi_oe, 2'b01);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            nbad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule